// File: doc/BRIEF.md
# Multi-Page-Size Translation Lookaside Buffer

This block translates a 32-bit effective address into a physical address. It holds a small set of translations and compares all of them against each request at once. Each stored translation has its own page size (4 KB, 16 KB, 512 KB or 8 MB), an address-space tag, a protection group and, for 4 KB pages, a separate allow bit for each 1 KB quarter of the page. A lookup returns a registered result one cycle later: a hit with the physical address, or a miss. A protection violation flag is raised when the matching translation denies the access.

Software loads translations through a refill port. The block picks the slot itself: the lowest empty slot if there is one, otherwise the slot named by a round-robin pointer. Single slots can be invalidated by index, and the whole array can be flushed. If two or more translations overlap and match, the block raises a multi-hit error and uses the lowest-numbered match.

Top module: `tlb_multi_page`

## Requirements
- R1: The array holds NUM_ENTRIES (default 8) translations, all compared in parallel. A lookup presented with `lookup_i` high produces a result with `rsp_valid_o` high on the next clock edge. `rsp_valid_o` is low in cycles with no lookup.
- R2: Page size encoding on `refill_size_i` is 0 = 4 KB, 1 = 16 KB, 2 = 512 KB and 3 = 8 MB. The effective-address bits compared against the stored page number are [31:12], [31:14], [31:19] and [31:23] respectively. Stored page-number bits below the boundary are ignored.
- R3: On a hit, `pa_o` takes the stored physical page number above the page boundary and the effective address below it. `pa_o[11:0]` always equals `ea_i[11:0]`.
- R4: A translation matches only when its address-space tag equals `asid_i`, unless its global bit is set, in which case the tag is ignored.
- R5: On a miss, `miss_o` is 1, `hit_o` is 0, and `pa_o`, `prot_viol_o` and `multi_hit_o` are 0.
- R6: For a 4 KB translation, sub-page `ea_i[11:10]` is allowed when bit `ea_i[11:10]` of its `refill_sub_allow_i` mask is 1. A clear bit gives `prot_viol_o` on a hit. For the other page sizes the mask has no effect.
- R7: A hit on a translation whose protection group g has `grp_deny_i[g]` set gives `prot_viol_o`.
- R8: A refill writes the lowest-numbered invalid slot when one exists, and it leaves the round-robin pointer unchanged.
- R9: When every slot is valid, a refill writes the slot named by the round-robin pointer, and the pointer then advances by one, wrapping. The pointer is 0 after reset.
- R10: When more than one translation matches, `multi_hit_o` is 1 and the result uses the lowest-numbered match.
- R11: `inval_i` clears slot `inval_idx_i` and `flush_i` clears all slots. In the same cycle, flush takes precedence over invalidate, and either one cancels a refill.
- R12: After reset, all slots are invalid and all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| lookup_i | input | 1 | Start a translation |
| ea_i | input | 32 | Effective address |
| asid_i | input | 4 | Current address-space tag |
| grp_deny_i | input | 16 | Deny bit per protection group |
| rsp_valid_o | output | 1 | Result valid |
| hit_o | output | 1 | Translation found |
| miss_o | output | 1 | No translation found |
| multi_hit_o | output | 1 | Several translations matched |
| prot_viol_o | output | 1 | Access denied by sub-page or group |
| pa_o | output | 32 | Physical address |
| refill_i | input | 1 | Load a translation |
| refill_vpn_i | input | 20 | Effective page number, address bits [31:12] |
| refill_ppn_i | input | 20 | Physical page number, address bits [31:12] |
| refill_size_i | input | 2 | Page size code |
| refill_asid_i | input | 4 | Address-space tag |
| refill_global_i | input | 1 | Match in any address space |
| refill_pgrp_i | input | 4 | Protection group |
| refill_sub_allow_i | input | 4 | Allow mask for 1 KB sub-pages |
| inval_i | input | 1 | Invalidate one slot |
| inval_idx_i | input | 3 | Slot to invalidate |
| flush_i | input | 1 | Invalidate all slots |

## Verification
On every cycle the assertions check that the result kinds stay consistent. A miss carries no address and never coexists with a hit. A violation or multi-hit only comes with a hit. The page offset passes through unchanged. A response follows every lookup. A refill that finds an empty slot lands in an empty slot, and a flush leaves no valid slot. Only the bench's scenarios can show which slot a refill chose, how the round-robin pointer advances, the exact address for each page size, the address-space and sub-page rules, and the same-cycle write priority. The bench observes all of these through later lookups.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  localparam int unsigned TLB_VA_W   = 32;
  localparam int unsigned TLB_OFF_W  = 12;
  localparam int unsigned TLB_VPN_W  = TLB_VA_W - TLB_OFF_W;
  localparam int unsigned TLB_ASID_W = 4;
  localparam int unsigned TLB_PGRP_W = 4;
  localparam int unsigned TLB_NGRP   = 1 << TLB_PGRP_W;
  localparam int unsigned TLB_NSUB   = 4;

  typedef enum logic [1:0] {
    PS_4K   = 2'd0,
    PS_16K  = 2'd1,
    PS_512K = 2'd2,
    PS_8M   = 2'd3
  } page_size_e;

  typedef struct packed {
    logic                  valid;
    logic                  glob;
    page_size_e            psize;
    logic [TLB_ASID_W-1:0] asid;
    logic [TLB_PGRP_W-1:0] pgrp;
    logic [TLB_NSUB-1:0]   sub_allow;
    logic [TLB_VPN_W-1:0]  vpn;
    logic [TLB_VPN_W-1:0]  ppn;
  } tlb_entry_t;

  // page-number bits that come from the effective address
  function automatic logic [TLB_VPN_W-1:0] pass_mask(page_size_e ps);
    unique case (ps)
      PS_4K:   pass_mask = TLB_VPN_W'(0);
      PS_16K:  pass_mask = TLB_VPN_W'(20'h00003);
      PS_512K: pass_mask = TLB_VPN_W'(20'h0007F);
      default: pass_mask = TLB_VPN_W'(20'h007FF);
    endcase
  endfunction
endpackage

// File: rtl/tlb_entry_match.sv
module tlb_entry_match
  import tlb_pkg::*;
(
  input  tlb_entry_t            entry_i,
  input  logic [TLB_VPN_W-1:0]  ea_vpn_i,
  input  logic [1:0]            sub_sel_i,
  input  logic [TLB_ASID_W-1:0] asid_i,
  input  logic [TLB_NGRP-1:0]   grp_deny_i,
  output logic                  hit_o,
  output logic [TLB_VPN_W-1:0]  pa_vpn_o,
  output logic                  viol_o
);
  logic [TLB_VPN_W-1:0] mask;
  logic                 tag_eq, asid_ok, sub_ok;

  assign mask     = pass_mask(entry_i.psize);
  assign tag_eq   = ((entry_i.vpn ^ ea_vpn_i) & ~mask) == '0;
  assign asid_ok  = entry_i.glob || (entry_i.asid == asid_i);
  assign hit_o    = entry_i.valid && tag_eq && asid_ok;
  assign pa_vpn_o = (entry_i.ppn & ~mask) | (ea_vpn_i & mask);
  assign sub_ok   = (entry_i.psize != PS_4K) || entry_i.sub_allow[sub_sel_i];
  assign viol_o   = !sub_ok || grp_deny_i[entry_i.pgrp];
endmodule

// File: rtl/tlb_hit_select.sv
module tlb_hit_select #(
  parameter int unsigned NUM_ENTRIES = 8,
  localparam int unsigned IDX_W = $clog2(NUM_ENTRIES)
) (
  input  logic [NUM_ENTRIES-1:0] hit_vec_i,
  output logic                   any_o,
  output logic                   multi_o,
  output logic [IDX_W-1:0]       idx_o
);
  always_comb begin
    idx_o = '0;
    for (int i = NUM_ENTRIES - 1; i >= 0; i--) begin
      if (hit_vec_i[i]) idx_o = IDX_W'(i);
    end
  end
  assign any_o   = |hit_vec_i;
  assign multi_o = $countones(hit_vec_i) > 1;
endmodule

// File: rtl/tlb_victim.sv
module tlb_victim #(
  parameter int unsigned NUM_ENTRIES = 8,
  localparam int unsigned IDX_W = $clog2(NUM_ENTRIES)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [NUM_ENTRIES-1:0] valid_vec_i,
  input  logic                   fire_i,
  output logic [IDX_W-1:0]       victim_o
);
  logic [IDX_W-1:0] rr_q, free_idx;
  logic             any_free;

  always_comb begin
    free_idx = '0;
    for (int i = NUM_ENTRIES - 1; i >= 0; i--) begin
      if (!valid_vec_i[i]) free_idx = IDX_W'(i);
    end
  end
  assign any_free = ~&valid_vec_i;
  assign victim_o = any_free ? free_idx : rr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rr_q <= '0;
    else if (fire_i && !any_free)
      rr_q <= (rr_q == IDX_W'(NUM_ENTRIES - 1)) ? '0 : rr_q + 1'b1;
  end

  // R8
  free_slot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fire_i && any_free) |-> !valid_vec_i[victim_o]);
endmodule

// File: rtl/tlb_multi_page.sv
module tlb_multi_page
  import tlb_pkg::*;
#(
  parameter int unsigned NUM_ENTRIES = 8,
  localparam int unsigned IDX_W = $clog2(NUM_ENTRIES)
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  lookup_i,
  input  logic [TLB_VA_W-1:0]   ea_i,
  input  logic [TLB_ASID_W-1:0] asid_i,
  input  logic [TLB_NGRP-1:0]   grp_deny_i,
  output logic                  rsp_valid_o,
  output logic                  hit_o,
  output logic                  miss_o,
  output logic                  multi_hit_o,
  output logic                  prot_viol_o,
  output logic [TLB_VA_W-1:0]   pa_o,
  input  logic                  refill_i,
  input  logic [TLB_VPN_W-1:0]  refill_vpn_i,
  input  logic [TLB_VPN_W-1:0]  refill_ppn_i,
  input  logic [1:0]            refill_size_i,
  input  logic [TLB_ASID_W-1:0] refill_asid_i,
  input  logic                  refill_global_i,
  input  logic [TLB_PGRP_W-1:0] refill_pgrp_i,
  input  logic [TLB_NSUB-1:0]   refill_sub_allow_i,
  input  logic                  inval_i,
  input  logic [IDX_W-1:0]      inval_idx_i,
  input  logic                  flush_i
);
  tlb_entry_t                 entries_q [NUM_ENTRIES];
  logic [NUM_ENTRIES-1:0]     valid_vec, hit_vec, viol_vec;
  logic [TLB_VPN_W-1:0]       pa_vpn [NUM_ENTRIES];
  logic                       any_hit, multi;
  logic [IDX_W-1:0]           sel_idx, victim;
  logic                       refill_fire;
  tlb_entry_t                 new_entry;

  for (genvar g = 0; g < NUM_ENTRIES; g++) begin : g_ent
    assign valid_vec[g] = entries_q[g].valid;
    tlb_entry_match i_match (
      .entry_i   (entries_q[g]),
      .ea_vpn_i  (ea_i[TLB_VA_W-1:TLB_OFF_W]),
      .sub_sel_i (ea_i[TLB_OFF_W-1:TLB_OFF_W-2]),
      .asid_i    (asid_i),
      .grp_deny_i(grp_deny_i),
      .hit_o     (hit_vec[g]),
      .pa_vpn_o  (pa_vpn[g]),
      .viol_o    (viol_vec[g])
    );
  end

  tlb_hit_select #(.NUM_ENTRIES(NUM_ENTRIES)) i_sel (
    .hit_vec_i(hit_vec),
    .any_o    (any_hit),
    .multi_o  (multi),
    .idx_o    (sel_idx)
  );

  // flush and invalidate cancel a refill in the same cycle
  assign refill_fire = refill_i && !flush_i && !inval_i;

  tlb_victim #(.NUM_ENTRIES(NUM_ENTRIES)) i_victim (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .valid_vec_i(valid_vec),
    .fire_i     (refill_fire),
    .victim_o   (victim)
  );

  always_comb begin
    new_entry.valid     = 1'b1;
    new_entry.glob      = refill_global_i;
    new_entry.psize     = page_size_e'(refill_size_i);
    new_entry.asid      = refill_asid_i;
    new_entry.pgrp      = refill_pgrp_i;
    new_entry.sub_allow = refill_sub_allow_i;
    new_entry.vpn       = refill_vpn_i;
    new_entry.ppn       = refill_ppn_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NUM_ENTRIES; i++) entries_q[i] <= '0;
    end else if (flush_i) begin
      for (int i = 0; i < NUM_ENTRIES; i++) entries_q[i].valid <= 1'b0;
    end else if (inval_i) begin
      entries_q[inval_idx_i].valid <= 1'b0;
    end else if (refill_fire) begin
      entries_q[victim] <= new_entry;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o <= 1'b0;
      hit_o       <= 1'b0;
      miss_o      <= 1'b0;
      multi_hit_o <= 1'b0;
      prot_viol_o <= 1'b0;
      pa_o        <= '0;
    end else begin
      rsp_valid_o <= lookup_i;
      hit_o       <= lookup_i && any_hit;
      miss_o      <= lookup_i && !any_hit;
      multi_hit_o <= lookup_i && multi;
      prot_viol_o <= lookup_i && any_hit && viol_vec[sel_idx];
      pa_o        <= (lookup_i && any_hit) ? {pa_vpn[sel_idx], ea_i[TLB_OFF_W-1:0]} : '0;
    end
  end

  // R1
  rsp_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lookup_i |=> rsp_valid_o);
  // R5
  miss_clean_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    miss_o |-> (!hit_o && pa_o == '0 && !prot_viol_o && !multi_hit_o));
  // R3
  offset_pass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |-> pa_o[TLB_OFF_W-1:0] == $past(ea_i[TLB_OFF_W-1:0]));
  // R6
  viol_needs_hit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prot_viol_o |-> hit_o);
  // R10
  multi_needs_hit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    multi_hit_o |-> hit_o);
  // R11
  flush_empty_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> valid_vec == '0);
endmodule

// File: tb/test_tlb_multi_page.sv
module test_tlb_multi_page;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        lookup_i = 1'b0;
  logic [31:0] ea_i = '0;
  logic [3:0]  asid_i = '0;
  logic [15:0] grp_deny_i = '0;
  logic        rsp_valid_o, hit_o, miss_o, multi_hit_o, prot_viol_o;
  logic [31:0] pa_o;
  logic        refill_i = 1'b0;
  logic [19:0] refill_vpn_i = '0, refill_ppn_i = '0;
  logic [1:0]  refill_size_i = '0;
  logic [3:0]  refill_asid_i = '0;
  logic        refill_global_i = 1'b0;
  logic [3:0]  refill_pgrp_i = '0;
  logic [3:0]  refill_sub_allow_i = '0;
  logic        inval_i = 1'b0;
  logic [2:0]  inval_idx_i = '0;
  logic        flush_i = 1'b0;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #10 clk_i = ~clk_i;

  tlb_multi_page i_tlb_multi_page (.*);

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // sampled results
  logic r_vld, r_hit, r_miss, r_multi, r_viol;
  logic [31:0] r_pa;

  task automatic lookup(input logic [31:0] ea, input logic [3:0] asid);
    @(negedge clk_i);
    lookup_i = 1'b1; ea_i = ea; asid_i = asid;
    @(negedge clk_i);
    lookup_i = 1'b0;
    r_vld = rsp_valid_o; r_hit = hit_o; r_miss = miss_o;
    r_multi = multi_hit_o; r_viol = prot_viol_o; r_pa = pa_o;
  endtask

  task automatic refill(input logic [19:0] vpn, input logic [19:0] ppn, input logic [1:0] sz,
                        input logic [3:0] asid, input logic glob, input logic [3:0] grp,
                        input logic [3:0] sub);
    @(negedge clk_i);
    refill_i = 1'b1; refill_vpn_i = vpn; refill_ppn_i = ppn; refill_size_i = sz;
    refill_asid_i = asid; refill_global_i = glob; refill_pgrp_i = grp; refill_sub_allow_i = sub;
    @(negedge clk_i);
    refill_i = 1'b0;
  endtask

  task automatic simple_fill(input logic [19:0] vpn, input logic [19:0] ppn);
    refill(vpn, ppn, 2'd0, 4'd0, 1'b0, 4'd0, 4'hF);
  endtask

  task automatic inval(input logic [2:0] idx);
    @(negedge clk_i); inval_i = 1'b1; inval_idx_i = idx;
    @(negedge clk_i); inval_i = 1'b0;
  endtask

  task automatic flush();
    @(negedge clk_i); flush_i = 1'b1;
    @(negedge clk_i); flush_i = 1'b0;
  endtask

  task automatic expect_hit(input logic [31:0] ea, input logic [3:0] asid, input logic [31:0] pa, input string req);
    lookup(ea, asid);
    chk(r_vld && r_hit && !r_miss, req, {31'd0, r_hit}, 32'd1);
    chk(r_pa == pa, req, r_pa, pa);
  endtask

  task automatic expect_miss(input logic [31:0] ea, input logic [3:0] asid, input string req);
    lookup(ea, asid);
    chk(r_vld && r_miss && !r_hit && r_pa == 0 && !r_viol && !r_multi, req, {31'd0, r_miss}, 32'd1);
  endtask

  task automatic t_reset();
    chk(!rsp_valid_o && !hit_o && !miss_o && !multi_hit_o && !prot_viol_o && pa_o == 0,
        "R12 outputs", pa_o, 32'd0);
    expect_miss(32'h0000_0000, 4'd0, "R12 empty after reset");
    expect_miss(32'h1234_5678, 4'd0, "R5 miss");
    @(negedge clk_i);
    chk(!rsp_valid_o, "R1 idle no response", {31'd0, rsp_valid_o}, 32'd0);
  endtask

  task automatic t_sizes();
    flush();
    refill(20'h10000, 20'hAAAAA, 2'd0, 4'd0, 1'b0, 4'd0, 4'hF); // slot 0
    refill(20'h20004, 20'h55557, 2'd1, 4'd0, 1'b0, 4'd0, 4'h0); // slot 1
    refill(20'h30000, 20'h12380, 2'd2, 4'd0, 1'b0, 4'd0, 4'h0); // slot 2
    refill(20'h40000, 20'h80000, 2'd3, 4'd0, 1'b0, 4'd0, 4'h0); // slot 3
    expect_hit(32'h1000_0ABC, 4'd0, 32'hAAAA_AABC, "R2 R3 4K");
    expect_miss(32'h1000_1000, 4'd0, "R2 4K boundary");
    expect_hit(32'h2000_7ABC, 4'd0, 32'h5555_7ABC, "R2 R3 16K");
    expect_miss(32'h2000_8000, 4'd0, "R2 16K boundary");
    expect_hit(32'h3007_F123, 4'd0, 32'h123F_F123, "R2 R3 512K");
    expect_miss(32'h3008_0000, 4'd0, "R2 512K boundary");
    expect_hit(32'h407F_FFFC, 4'd0, 32'h807F_FFFC, "R2 R3 8M");
    expect_miss(32'h4080_0000, 4'd0, "R2 8M boundary");
    inval(3'd1);
    expect_miss(32'h2000_4000, 4'd0, "R8 R11 slot1 holds 16K");
    expect_hit(32'h3000_0000, 4'd0, 32'h1238_0000, "R11 others kept");
    refill(20'h21000, 20'h0BEEF, 2'd0, 4'd0, 1'b0, 4'd0, 4'hF);   // fills slot 1
    inval(3'd1);
    expect_miss(32'h2100_0000, 4'd0, "R8 refill took lowest free slot");
  endtask

  task automatic t_asid();
    flush();
    refill(20'h0A000, 20'h01000, 2'd0, 4'd5, 1'b0, 4'd0, 4'hF);
    refill(20'h0B000, 20'h02000, 2'd0, 4'd3, 1'b1, 4'd0, 4'hF);
    expect_hit(32'h0A00_0010, 4'd5, 32'h0100_0010, "R4 asid match");
    expect_miss(32'h0A00_0010, 4'd6, "R4 asid mismatch");
    expect_hit(32'h0B00_0020, 4'd9, 32'h0200_0020, "R4 global");
  endtask

  task automatic t_prot();
    flush();
    refill(20'h0C000, 20'h03000, 2'd0, 4'd0, 1'b0, 4'd2, 4'b0101);
    refill(20'h0D000, 20'h04000, 2'd1, 4'd0, 1'b0, 4'd7, 4'b0000);
    lookup(32'h0C00_0000, 4'd0);
    chk(r_hit && !r_viol, "R6 sub-page 0 allowed", {31'd0, r_viol}, 32'd0);
    lookup(32'h0C00_0400, 4'd0);
    chk(r_hit && r_viol, "R6 sub-page 1 denied", {31'd0, r_viol}, 32'd1);
    lookup(32'h0C00_0800, 4'd0);
    chk(r_hit && !r_viol, "R6 sub-page 2 allowed", {31'd0, r_viol}, 32'd0);
    lookup(32'h0D00_0C00, 4'd0);
    chk(r_hit && !r_viol, "R6 mask ignored on 16K", {31'd0, r_viol}, 32'd0);
    grp_deny_i = 16'h0004;
    lookup(32'h0C00_0000, 4'd0);
    chk(r_hit && r_viol, "R7 group denied", {31'd0, r_viol}, 32'd1);
    lookup(32'h0D00_0000, 4'd0);
    chk(r_hit && !r_viol, "R7 other group allowed", {31'd0, r_viol}, 32'd0);
    expect_miss(32'h0E00_0000, 4'd0, "R5 miss no violation");
    grp_deny_i = '0;
  endtask

  task automatic t_multi();
    flush();
    refill(20'h50000, 20'h11111, 2'd0, 4'd0, 1'b0, 4'd0, 4'hF);
    refill(20'h50000, 20'h22220, 2'd1, 4'd0, 1'b0, 4'd0, 4'hF);
    lookup(32'h5000_0123, 4'd0);
    chk(r_hit && r_multi, "R10 multi flag", {31'd0, r_multi}, 32'd1);
    chk(r_pa == 32'h1111_1123, "R10 lowest index", r_pa, 32'h1111_1123);
    inval(3'd0);
    lookup(32'h5000_0123, 4'd0);
    chk(r_hit && !r_multi, "R10 single hit", {31'd0, r_multi}, 32'd0);
    chk(r_pa == 32'h2222_0123, "R10 remaining entry", r_pa, 32'h2222_0123);
  endtask

  task automatic t_rr();
    flush();
    for (int i = 0; i < 8; i++) simple_fill(20'h60000 + 20'(i), 20'h00100 + 20'(i));
    for (int i = 0; i < 8; i++)
      expect_hit({20'h60000 + 20'(i), 12'h0}, 4'd0, {20'h00100 + 20'(i), 12'h0}, "R1 eight slots");
    simple_fill(20'h70000, 20'h00200);
    expect_miss(32'h6000_0000, 4'd0, "R9 pointer 0 replaced");
    expect_hit(32'h7000_0000, 4'd0, 32'h0020_0000, "R9 new entry");
    simple_fill(20'h70001, 20'h00201);
    expect_miss(32'h6000_1000, 4'd0, "R9 pointer 1 replaced");
    inval(3'd5);
    simple_fill(20'h70002, 20'h00202);
    expect_hit(32'h7000_2000, 4'd0, 32'h0020_2000, "R8 refill into freed slot");
    expect_hit(32'h6000_2000, 4'd0, 32'h0010_2000, "R8 pointer slot kept");
    simple_fill(20'h70003, 20'h00203);
    expect_miss(32'h6000_2000, 4'd0, "R9 pointer 2 after free refill");
    expect_hit(32'h6000_3000, 4'd0, 32'h0010_3000, "R9 slot 3 kept");
  endtask

  task automatic t_priority();
    flush();
    @(negedge clk_i);
    refill_i = 1'b1; refill_vpn_i = 20'h80000; refill_ppn_i = 20'h00300;
    refill_size_i = 2'd0; refill_asid_i = 4'd0; refill_global_i = 1'b0; refill_sub_allow_i = 4'hF;
    flush_i = 1'b1;
    @(negedge clk_i);
    refill_i = 1'b0; flush_i = 1'b0;
    expect_miss(32'h8000_0000, 4'd0, "R11 flush cancels refill");
    @(negedge clk_i);
    refill_i = 1'b1; inval_i = 1'b1; inval_idx_i = 3'd4;
    @(negedge clk_i);
    refill_i = 1'b0; inval_i = 1'b0;
    expect_miss(32'h8000_0000, 4'd0, "R11 invalidate cancels refill");
    simple_fill(20'h80000, 20'h00300);
    expect_hit(32'h8000_0000, 4'd0, 32'h0030_0000, "R11 plain refill");
  endtask

  initial begin
    #200_000_000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    chk(pa_o == 0 && !hit_o && !rsp_valid_o, "R12 in reset", pa_o, 32'd0);
    rst_ni = 1'b1;
    t_reset();
    t_sizes();
    t_asid();
    t_prot();
    t_multi();
    t_rr();
    t_priority();
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule